// File: doc/BRIEF.md
# Bit-Serial Adder with Operand-Preserving Shift Registers

The block adds two unsigned operands one bit position per clock cycle. It uses a single full adder and a one-bit carry register. Both operands sit in registers that shift right, so the least significant bits meet in the adder first. The sum bits enter the first operand register at its top as it shifts, so after a full pass that register holds the sum. The second operand's outgoing bit is routed straight back into its own top, which leaves it intact when the pass ends. The carry out of the top bit position is kept and driven on a port.

Operands are loaded serially through a valid/ready stream, before any addition. Each accepted beat carries one bit for each register. Beats must arrive least significant bit first, so eight beats fill both registers. A start pulse launches the addition. A small controller then clears the carry and a step counter, and runs exactly WIDTH shift steps. It signals completion with a one-cycle done pulse.

Top module: `serial_adder`

## Requirements
- R1: After reset the block is idle: busy, done, carry_out, a_sum and b_val are all 0, and ld_ready is 1 while start is low.
- R2: Each load beat accepted (ld_valid and ld_ready both 1 at a rising edge) shifts both registers right by one bit. ld_a_bit enters bit WIDTH-1 of register A and ld_b_bit enters bit WIDTH-1 of register B. After WIDTH beats sent least significant bit first, the registers hold the sent operands.
- R3: Back-pressure: ld_ready is 0 whenever busy is 1 or start is 1. A beat offered while ld_ready is 0 is not taken and changes neither register.
- R4: When start is 1 at a rising edge while the block is idle, busy is 1 from the next cycle on. The carry register is cleared to 0 before the first step, so a carry left over from an earlier addition does not enter the new sum.
- R5: When done is 1, a_sum equals the low WIDTH bits of the sum of the A and B values held at start.
- R6: When done is 1, b_val equals the value B held at start.
- R7: When done is 1, carry_out equals bit WIDTH of that sum. It keeps this value until the next start.
- R8: busy stays 1 for exactly WIDTH cycles. done is 1 for exactly one cycle, the cycle right after the last step, and busy is 0 in that cycle.
- R9: A start pulse during an addition is ignored. The step count and the result are the same as without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches an addition when idle |
| ld_valid | input | 1 | A load beat is offered |
| ld_ready | output | 1 | A load beat can be taken |
| ld_a_bit | input | 1 | Serial bit for register A |
| ld_b_bit | input | 1 | Serial bit for register B |
| a_sum | output | WIDTH | Register A: operand before the addition, sum after it |
| b_val | output | WIDTH | Register B contents |
| carry_out | output | 1 | Carry out of the top bit of the last addition |
| busy | output | 1 | An addition is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded properties check, on every cycle, the following:
- ld_ready stays low while busy.
- An unaccepted cycle leaves both registers unchanged.
- done lasts a single cycle.
- Each addition takes exactly WIDTH steps.
- At done, the sum, the kept carry and the preserved B match snapshots taken at start.
- A start pulse during a run does not disturb the step counter.

The bench's scenarios are needed for the rest: the bit order of the serial load, the way the reset state looks at the ports, and the clearing of a leftover carry between back-to-back additions. It sweeps every A value against many B values and compares each result with sums it computes itself.

// File: rtl/sa_pkg.sv
package sa_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sa_state_e;
endpackage

// File: rtl/sa_full_adder.sv
module sa_full_adder (
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic s,
  output logic cout
);
  always_comb begin
    s    = x ^ y ^ cin;
    cout = (x & y) | (cin & (x ^ y));
  end
endmodule

// File: rtl/sa_shreg.sv
module sa_shreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift,
  input  logic             sel_ext,
  input  logic             ext_bit,
  input  logic             loop_bit,
  output logic [WIDTH-1:0] q,
  output logic             lsb
);
  logic in_bit;

  always_comb in_bit = sel_ext ? ext_bit : loop_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (shift) q <= {in_bit, q[WIDTH-1:1]};
  end

  assign lsb = q[0];

  AST_HOLD_WITHOUT_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(q)); // R3
endmodule

// File: rtl/sa_ctrl.sv
module sa_ctrl
  import sa_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ld_valid,
  output logic ld_ready,
  output logic shift_a,
  output logic shift_b,
  output logic sel_a,
  output logic sel_b,
  output logic clr_carry,
  output logic step,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  sa_state_e      state;
  logic [CNT_W-1:0] cnt;
  logic           done_q;
  logic           run, last, accept, clr_cnt, ld_fire;

  always_comb begin
    run       = (state == ST_RUN);
    last      = (cnt == LAST);
    accept    = !run && start;
    clr_cnt   = accept;
    clr_carry = accept;
    ld_ready  = !run && !start;
    ld_fire   = ld_valid && ld_ready;
    shift_a   = run || ld_fire;
    shift_b   = run || ld_fire;
    sel_a     = !run;
    sel_b     = !run;
    step      = run;
    busy      = run;
    done      = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= run && last;
      if (accept)          state <= ST_RUN;
      else if (run && last) state <= ST_IDLE;
      if (clr_cnt)   cnt <= '0;
      else if (run)  cnt <= cnt + CNT_W'(1);
    end
  end

  AST_READY_LOW_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ld_ready); // R3
  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_RESTART_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start && !last) |=> (busy && cnt == $past(cnt) + CNT_W'(1))); // R9
endmodule

// File: rtl/serial_adder.sv
module serial_adder #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic             ld_a_bit,
  input  logic             ld_b_bit,
  output logic [WIDTH-1:0] a_sum,
  output logic [WIDTH-1:0] b_val,
  output logic             carry_out,
  output logic             busy,
  output logic             done
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH + 1) + 1 : 2;

  logic shift_a, shift_b, sel_a, sel_b, clr_carry, step;
  logic a_lsb, b_lsb, sum_bit, cout_bit, carry_q;

  sa_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .ld_valid(ld_valid),
    .ld_ready(ld_ready), .shift_a(shift_a), .shift_b(shift_b),
    .sel_a(sel_a), .sel_b(sel_b), .clr_carry(clr_carry), .step(step),
    .busy(busy), .done(done)
  );

  sa_shreg #(.WIDTH(WIDTH)) u_reg_a (
    .clk(clk), .rst_n(rst_n), .shift(shift_a), .sel_ext(sel_a),
    .ext_bit(ld_a_bit), .loop_bit(sum_bit), .q(a_sum), .lsb(a_lsb)
  );

  sa_shreg #(.WIDTH(WIDTH)) u_reg_b (
    .clk(clk), .rst_n(rst_n), .shift(shift_b), .sel_ext(sel_b),
    .ext_bit(ld_b_bit), .loop_bit(b_lsb), .q(b_val), .lsb(b_lsb)
  );

  sa_full_adder u_fa (
    .x(a_lsb), .y(b_lsb), .cin(carry_q), .s(sum_bit), .cout(cout_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         carry_q <= 1'b0;
    else if (clr_carry) carry_q <= 1'b0;
    else if (step)      carry_q <= cout_bit;
  end

  assign carry_out = carry_q;

  // Checker state: operand snapshots and a run-length counter.
  logic [WIDTH-1:0] snap_a, snap_b;
  logic [CW-1:0]    run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_a  <= '0;
      snap_b  <= '0;
      run_len <= '0;
    end else begin
      if (start && !busy) begin
        snap_a  <= a_sum;
        snap_b  <= b_val;
        run_len <= '0;
      end else if (busy) begin
        run_len <= run_len + CW'(1);
      end
    end
  end

  AST_SUM_AND_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({carry_out, a_sum} == ((WIDTH+1)'(snap_a) + (WIDTH+1)'(snap_b)))); // R5 R7
  AST_B_PRESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (b_val == snap_b)); // R6
  AST_EXACT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_len == CW'(WIDTH))); // R8
endmodule

// File: tb/tb_serial_adder.sv
`timescale 1ns/1ps
module tb_serial_adder;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0, ld_valid = 1'b0, ld_a_bit = 1'b0, ld_b_bit = 1'b0;
  logic         ld_ready, carry_out, busy, done;
  logic [W-1:0] a_sum, b_val;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  serial_adder #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ld_valid(ld_valid),
    .ld_ready(ld_ready), .ld_a_bit(ld_a_bit), .ld_b_bit(ld_b_bit),
    .a_sum(a_sum), .b_val(b_val), .carry_out(carry_out),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic load(input logic [W-1:0] a, input logic [W-1:0] b);
    for (int k = 0; k < W; k++) begin
      @(negedge clk);
      ld_valid = 1'b1; ld_a_bit = a[k]; ld_b_bit = b[k];
      if (k == 0) chk("R3 ready when idle", ld_ready, 1);
    end
    @(negedge clk);
    ld_valid = 1'b0;
    chk("R2 A loaded", a_sum, a);
    chk("R2 B loaded", b_val, b);
  endtask

  task automatic add(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke);
    logic [W:0] s;
    int n;
    s = {1'b0, a} + {1'b0, b};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R4 busy after start", busy, 1);
    n = 0;
    while (busy && n < 20) begin
      n++;
      if (poke && n == 3) begin
        start = 1'b1; ld_valid = 1'b1; ld_a_bit = 1'b1; ld_b_bit = 1'b1;
        chk("R3 ready low while busy", ld_ready, 0);
      end else begin
        start = 1'b0; ld_valid = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0; ld_valid = 1'b0;
    chk(poke ? "R9 steps with restart" : "R8 busy length", n, W);
    chk("R8 done pulse", done, 1);
    chk("R5 sum", a_sum, s[W-1:0]);
    chk("R6 B preserved", b_val, b);
    chk("R7 carry out", carry_out, s[W]);
    @(negedge clk);
    chk("R8 done one cycle", done, 0);
    chk("R7 carry held", carry_out, s[W]);
  endtask

  initial begin
    #1;
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset carry", carry_out, 0);
    chk("R1 reset A", a_sum, 0);
    chk("R1 reset B", b_val, 0);
    chk("R1 reset ready", ld_ready, 1);
    #10 rst_n = 1'b1;
    @(negedge clk);

    // R3: start high blocks ready, and the offered beat is not taken
    load(8'h11, 8'h22);
    start = 1'b1; ld_valid = 1'b1; ld_a_bit = 1'b1; ld_b_bit = 1'b1;
    #0;
    chk("R3 ready low with start", ld_ready, 0);
    @(negedge clk);
    start = 1'b0; ld_valid = 1'b0;
    while (busy) @(negedge clk);
    chk("R3 beat not taken (A)", a_sum, 8'h33);
    chk("R3 beat not taken (B)", b_val, 8'h22);
    @(negedge clk);

    // R4: leftover carry must not leak: FF+01 sets carry, then 00+00
    load(8'hFF, 8'h01);
    add(8'hFF, 8'h01, 1'b0);
    load(8'h00, 8'h00);
    add(8'h00, 8'h00, 1'b0);

    // Sweep: every A against 24 B values each
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 24; j++) begin
        logic [W-1:0] av, bv;
        av = W'(i);
        bv = W'(j * 11 + i * 3 + (j == 23 ? 255 : 0));
        load(av, bv);
        add(av, bv, (i % 16 == 0) && (j < 2));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule